// File: doc/BRIEF.md
# Timer-Triggered Pulse Output Port

This block drives stepper-motor style patterns on eight output pins arranged as two groups of four lanes. Software writes a four-bit pattern into a per-group staging register. The pattern reaches the pins only when that group's timer reports a count-reaches-zero event. Each timer event moves the staged pattern into a per-group output latch, so a new motor phase appears on an exact timer boundary, however late software wrote it.

A control register has several jobs. It hands each group over to pulse duty, or leaves it as an ordinary parallel port that drives the fallback port data. It can gate each group's lanes with an external PWM signal, and it can invert every pulse lane. The timers and PWM generators sit outside the block and arrive only as a one-cycle zero strobe and a level per group.

Registers are written through a small select/data interface:
- select 0 is the control register;
- select 1 is the group 0 staging register;
- select 2 is the group 1 staging register;
- select 3 is ignored.

Top module: `ppo_top`

## Requirements
- R1: After synchronous reset, every staging register, output latch and control bit is 0, so all eight pins equal `port_fb`.
- R2: Pins of a group that is not enabled equal the matching bits of `port_fb`: group 0 is pins[3:0] and group 1 is pins[7:4].
- R3: Control bit 1 enables group 0 (pins[3:0]) and control bit 0 enables group 1 (pins[7:4]). The two bits are independent and may both be set.
- R4: Writing a staging register (select 1 or 2, low four bits of `wr_data`) leaves the pins unchanged until that group's zero strobe.
- R5: On `zero_g0` the group 0 latch loads staging register 0. On `zero_g1` the group 1 latch loads staging register 1. A strobe for one group never changes the other group's latch.
- R6: With no gating and no inversion, an enabled lane whose latched bit is 0 drives 0, and one whose latched bit is 1 drives 1.
- R7: When a staging write and that group's zero strobe fall in the same cycle, the latch takes the previous staging value. The new value is loaded at the following strobe.
- R8: Control bit 4 gates group 0 and control bit 5 gates group 1. Each gated lane equals its latched bit ANDed with the group's PWM input (`pwm_g0` or `pwm_g1`).
- R9: Control bit 3 inverts every enabled pulse lane, applied after PWM gating. Pins of a disabled group are never inverted.
- R10: A group's latch follows its zero strobe even while the group is disabled, so enabling the group later shows the most recently latched pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 staging 0, 2 staging 1 |
| wr_data | input | 8 | Write data |
| zero_g0 | input | 1 | Group 0 timer zero strobe |
| zero_g1 | input | 1 | Group 1 timer zero strobe |
| pwm_g0 | input | 1 | PWM level for group 0 gating |
| pwm_g1 | input | 1 | PWM level for group 1 gating |
| port_fb | input | 8 | Parallel-port fallback data |
| pins | output | 8 | Output pins |

## Verification
The bench aims at the cross-wired control bits. A design that swapped them would light the upper nibble when bit 1 is set. It also drives a staging write and a zero strobe in the same cycle. A latch fed from the write bus instead of the staging register would then show the new nibble one strobe early. Further tests confirm that inversion comes after gating, so a gated-off lane reads high when inverted, and that a strobe for one group leaves the other group's pins alone. Finally, a group is loaded while disabled, which catches a latch that wrongly waits for its enable bit.

// File: rtl/ppo_pkg.sv
package ppo_pkg;

    localparam int LANES  = 4;
    localparam int GROUPS = 2;
    localparam int BUS_W  = 8;
    localparam int SEL_W  = 2;
    localparam int PINS_W = LANES * GROUPS;

    // control-byte bit positions (software-visible)
    localparam int CB_EN_G1  = 0;
    localparam int CB_EN_G0  = 1;
    localparam int CB_INVERT = 3;
    localparam int CB_PWM_G0 = 4;
    localparam int CB_PWM_G1 = 5;

    typedef logic [LANES-1:0] lane_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL  = 2'd0,
        SEL_STG0  = 2'd1,
        SEL_STG1  = 2'd2,
        SEL_SPARE = 2'd3
    } sel_e;

    typedef struct packed {
        logic [GROUPS-1:0] gate;
        logic              invert;
        logic [GROUPS-1:0] enable;
    } ctrl_t;

    function automatic ctrl_t decode_ctrl(input logic [BUS_W-1:0] b);
        ctrl_t c;
        c.enable[0] = b[CB_EN_G0];
        c.enable[1] = b[CB_EN_G1];
        c.invert    = b[CB_INVERT];
        c.gate[0]   = b[CB_PWM_G0];
        c.gate[1]   = b[CB_PWM_G1];
        return c;
    endfunction

    function automatic sel_e stage_sel(input int g);
        return (g == 0) ? SEL_STG0 : SEL_STG1;
    endfunction

endpackage

// File: rtl/ppo_regs.sv
module ppo_regs
    import ppo_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [SEL_W-1:0]         wr_sel,
    input  logic [BUS_W-1:0]         wr_data,
    output ctrl_t                    ctrl_o,
    output logic [GROUPS-1:0][LANES-1:0] stage_o
);

    ctrl_t ctrl_q;
    logic  unused_bits;

    assign unused_bits = ^{wr_data[7:6], wr_data[2]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en && sel_e'(wr_sel) == SEL_CTRL) begin
            ctrl_q <= decode_ctrl(wr_data);
        end
    end

    assign ctrl_o = ctrl_q;

    assert_ctrl_write_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_CTRL) |=> (ctrl_o == decode_ctrl($past(wr_data))));

    for (genvar g = 0; g < GROUPS; g++) begin : g_stage
        lane_t stg_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                stg_q <= '0;
            end else if (wr_en && sel_e'(wr_sel) == stage_sel(g)) begin
                stg_q <= wr_data[LANES-1:0];
            end
        end

        assign stage_o[g] = stg_q;

        assert_stage_write_R4: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_sel == stage_sel(g)) |=> (stage_o[g] == $past(wr_data[LANES-1:0])));

        assert_stage_hold_R4: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && wr_sel == stage_sel(g)) |=> $stable(stage_o[g]));
    end

endmodule

// File: rtl/ppo_shape.sv
module ppo_shape
    import ppo_pkg::*;
#(
    parameter int W = LANES
) (
    input  logic [W-1:0] data_i,
    input  logic         gate_i,
    input  logic         pwm_i,
    input  logic         invert_i,
    output logic [W-1:0] data_o
);

    logic [W-1:0] gated;

    always_comb begin
        gated  = gate_i ? (data_i & {W{pwm_i}}) : data_i;
        data_o = invert_i ? ~gated : gated;
    end

endmodule

// File: rtl/ppo_group.sv
module ppo_group
    import ppo_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  lane_t stage_i,
    input  logic  zero_i,
    input  logic  enable_i,
    input  logic  gate_i,
    input  logic  pwm_i,
    input  logic  invert_i,
    input  lane_t fallback_i,
    output lane_t pins_o
);

    lane_t latch_q;
    lane_t shaped;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
        end else if (zero_i) begin
            latch_q <= stage_i;
        end
    end

    ppo_shape #(.W(LANES)) u_shape (
        .data_i   (latch_q),
        .gate_i   (gate_i),
        .pwm_i    (pwm_i),
        .invert_i (invert_i),
        .data_o   (shaped)
    );

    assign pins_o = enable_i ? shaped : fallback_i;

    assert_latch_load_R7: assert property (@(posedge clk) disable iff (rst)
        zero_i |=> (latch_q == $past(stage_i)));

    assert_latch_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !zero_i |=> $stable(latch_q));

    assert_gate_off_R8: assert property (@(posedge clk) disable iff (rst)
        (enable_i && gate_i && !pwm_i && !invert_i) |-> (pins_o == '0));

    assert_invert_order_R9: assert property (@(posedge clk) disable iff (rst)
        (enable_i && gate_i && !pwm_i && invert_i) |-> (pins_o == '1));

    assert_disabled_R2: assert property (@(posedge clk) disable iff (rst)
        !enable_i |-> (pins_o == fallback_i));

endmodule

// File: rtl/ppo_top.sv
module ppo_top
    import ppo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic              zero_g0,
    input  logic              zero_g1,
    input  logic              pwm_g0,
    input  logic              pwm_g1,
    input  logic [PINS_W-1:0] port_fb,
    output logic [PINS_W-1:0] pins
);

    ctrl_t                        ctrl;
    logic [GROUPS-1:0][LANES-1:0] stage;
    logic [GROUPS-1:0]            zero_v;
    logic [GROUPS-1:0]            pwm_v;

    assign zero_v = {zero_g1, zero_g0};
    assign pwm_v  = {pwm_g1, pwm_g0};

    ppo_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .ctrl_o  (ctrl),
        .stage_o (stage)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        ppo_group u_grp (
            .clk        (clk),
            .rst        (rst),
            .stage_i    (stage[g]),
            .zero_i     (zero_v[g]),
            .enable_i   (ctrl.enable[g]),
            .gate_i     (ctrl.gate[g]),
            .pwm_i      (pwm_v[g]),
            .invert_i   (ctrl.invert),
            .fallback_i (port_fb[g*LANES +: LANES]),
            .pins_o     (pins[g*LANES +: LANES])
        );
    end

    assert_reset_pins_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pins == port_fb));

endmodule

// File: tb/ppo_top_test.sv
`timescale 1ns/1ps
module ppo_top_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [1:0] wr_sel;
    logic [7:0] wr_data;
    logic       zero_g0, zero_g1, pwm_g0, pwm_g1;
    logic [7:0] port_fb;
    logic [7:0] pins;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    ppo_top uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .zero_g0(zero_g0), .zero_g1(zero_g1), .pwm_g0(pwm_g0), .pwm_g1(pwm_g1),
        .port_fb(port_fb), .pins(pins)
    );

    task automatic check(input string req, input logic [7:0] exp);
        #1;
        total++;
        if (pins !== exp) begin
            bad++;
            $display("FAIL %s: pins=%h expected=%h", req, pins, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic fire(input bit g0, input bit g1);
        @(negedge clk);
        zero_g0 = g0; zero_g1 = g1;
        @(negedge clk);
        zero_g0 = 1'b0; zero_g1 = 1'b0;
    endtask

    task automatic t_reset;
        port_fb = 8'hA5;
        check("R1", 8'hA5);
        port_fb = 8'h3C;
        check("R2", 8'h3C);
    endtask

    task automatic t_enable_load;
        write_reg(2'd1, 8'h09);
        write_reg(2'd2, 8'h06);
        check("R4", 8'h3C);
        write_reg(2'd0, 8'h02);           // group 0 only
        check("R3", 8'h30);               // latch still 0, upper = fallback
        fire(1, 0);
        check("R5", 8'h39);
        write_reg(2'd0, 8'h01);           // group 1 only
        check("R3", 8'h0C);
        fire(0, 1);
        check("R5", 8'h6C);
        write_reg(2'd0, 8'h03);
        check("R3", 8'h69);
    endtask

    task automatic t_staging;
        write_reg(2'd1, 8'h03);
        check("R4", 8'h69);
        fire(0, 1);
        check("R5", 8'h69);               // other group's strobe
        fire(1, 0);
        check("R5", 8'h63);
        write_reg(2'd1, 8'h0F);
        fire(1, 0);
        check("R6", 8'h6F);
        write_reg(2'd1, 8'h00);
        fire(1, 0);
        check("R6", 8'h60);
        write_reg(2'd1, 8'h03);
        fire(1, 0);
    endtask

    task automatic t_collide;
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd1; wr_data = 8'h0C; zero_g0 = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; zero_g0 = 1'b0;
        check("R7", 8'h63);
        fire(1, 0);
        check("R7", 8'h6C);
    endtask

    task automatic t_pwm;
        pwm_g0 = 1'b0; pwm_g1 = 1'b1;
        write_reg(2'd0, 8'h33);
        check("R8", 8'h60);
        pwm_g0 = 1'b1;
        check("R8", 8'h6C);
        pwm_g1 = 1'b0;
        check("R8", 8'h0C);
        write_reg(2'd0, 8'h13);           // gate group 0 only
        check("R8", 8'h6C);
    endtask

    task automatic t_invert;
        pwm_g0 = 1'b1; pwm_g1 = 1'b1;
        write_reg(2'd0, 8'h0B);
        check("R9", 8'h93);
        write_reg(2'd0, 8'h0A);           // group 1 disabled
        check("R9", 8'h33);
        pwm_g0 = 1'b0;
        write_reg(2'd0, 8'h1A);
        check("R9", 8'h3F);
    endtask

    task automatic t_disabled_load;
        write_reg(2'd0, 8'h00);
        write_reg(2'd1, 8'h05);
        fire(1, 0);
        check("R10", 8'h3C);
        write_reg(2'd0, 8'h02);
        check("R10", 8'h35);
    endtask

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: pins=%h expected=finish", pins);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        zero_g0 = 1'b0; zero_g1 = 1'b0; pwm_g0 = 1'b0; pwm_g1 = 1'b0;
        port_fb = 8'hA5;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_enable_load();
        t_staging();
        t_collide();
        t_pwm();
        t_invert();
        t_disabled_load();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule